// File: doc/BRIEF.md
# Dual-Channel Converter Serial Readout Controller

This block is the host side of the serial link to a two-channel, simultaneous-sampling 12-bit converter. On a start pulse it drives an active-low chip select low, which makes both converters sample at the same instant. It then generates a serial clock from a divided system clock and reads one data-out line from the device. The line stays undriven through a long conversion window. The first result follows MSB first, and in an extended frame the other converter's result follows on the same line. This lets a single port collect both channels.

The frame type is chosen per frame. A short frame of 31 serial clocks returns the converter wired to the sampled line. A long frame of 45 serial clocks returns both converters. The results are sign-extended and presented together with a one-cycle valid pulse. A `line_is_b` input tells the controller which converter drives the sampled line, so the results can be routed to the correct channel outputs. The controller can also send a control word to the device, MSB first, on the data-in line during the frame. A programmable quiet time keeps chip select high between frames.

Top module: `dual_adc_reader`

## Requirements
- R1: While reset is held and just after it, `cs_n` and `sclk` are 1 and `busy`, `res_valid` and `adc_sdi` are 0.
- R2: A `start` seen while `busy` is 0 pulls `cs_n` low on the next clock and raises `busy`. `busy` stays high until the quiet time has ended.
- R3: A `start` that arrives while `busy` is 1 has no effect: no extra frame is run and no extra result is produced.
- R4: With `dual_mode` = 0 at launch, the frame has exactly 31 falling `sclk` edges while `cs_n` is low. With `dual_mode` = 1 it has exactly 45.
- R5: `sclk` is 1 whenever `cs_n` is 1. `cs_n` rises only after `sclk` has been high for at least one system clock following the last rising edge.
- R6: `adc_sdo` is sampled on the system clock just before each rising `sclk` edge. The first word is taken from the bits driven on falling edges 19 to 30, MSB first.
- R7: The values on `adc_sdo` outside the result windows (the conversion window and the gap bits) do not change any result.
- R8: Each 12-bit twos-complement word is sign-extended to the 16-bit result outputs.
- R9: In a long frame, the second word is taken from falling edges 33 to 44. If `line_is_b` = 0, the first word goes to `res_a` and the second to `res_b`; if `line_is_b` = 1, the routing is swapped. `res_pair` = 1 and `res_tag` = 0.
- R10: In a short frame, the word goes to `res_a` when `line_is_b` = 0 and to `res_b` when `line_is_b` = 1. The other result output is 0, `res_pair` = 0 and `res_tag` equals `line_is_b`.
- R11: `res_valid` is a single-cycle pulse, issued exactly once per frame, in the cycle in which `cs_n` returns high.
- R12: Between two frames, `cs_n` stays high for at least `quiet_cycles`+1 system clocks, even when `start` is held high.
- R13: With `ctrl_wr` = 1 at launch, `ctrl_word` is driven MSB first on `adc_sdi`, one bit per `sclk` falling edge from the first edge on, and changes only while `sclk` is high. With `ctrl_wr` = 0, `adc_sdi` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch one frame when idle |
| dual_mode | input | 1 | 1: 45-clock frame for both channels; 0: 31-clock frame |
| line_is_b | input | 1 | Sampled line belongs to converter B |
| quiet_cycles | input | QUIET_W | Minimum chip-select-high time between frames, minus one |
| ctrl_wr | input | 1 | Send `ctrl_word` during this frame |
| ctrl_word | input | CTRL_W | Control word for the device |
| adc_sdo | input | 1 | Serial data from the device |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Active-low chip select |
| adc_sdi | output | 1 | Serial data to the device |
| busy | output | 1 | Frame or quiet time in progress |
| res_valid | output | 1 | Results valid pulse |
| res_pair | output | 1 | Results come from a long frame |
| res_tag | output | 1 | Channel of a short-frame result (1 = B) |
| res_a | output | OUT_W | Channel A result, sign-extended |
| res_b | output | OUT_W | Channel B result, sign-extended |

## Verification
The hardest case to produce is a restart attempt that reaches the controller at an awkward moment. One such moment is a start held high across a frame boundary, which must still respect the quiet gap. Another is a start pulse that lands mid-frame, which must be dropped. The stimulus holds start high through two back-to-back long frames with a non-zero quiet time, and it also injects a pulse deep inside a busy frame. The bench's device model drives an alternating garbage pattern whenever no result bit is due, so a sampling window that is off by even one edge shows up as a wrong value.

// File: rtl/dar_pkg.sv
package dar_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_SETUP,
      S_RUN,
      S_HOLD,
      S_QUIET
   } dar_state_e;
endpackage

// File: rtl/dar_timer.sv
// Half-period / quiet-time counter: done when count reaches limit, then restarts.
module dar_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] limit,
   output logic         done
);
   logic [W-1:0] cnt;

   assign done = (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (clr || done)   cnt <= '0;
      else                    cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/dar_capture.sv
// Shifts in DW bits during cycles MSB_CYC..MSB_CYC+DW-1 and sign-extends.
module dar_capture #(
   parameter int DW      = 12,
   parameter int OW      = 16,
   parameter int MSB_CYC = 19,
   parameter int CYC_W   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             sample,
   input  logic [CYC_W-1:0] cyc,
   input  logic             bit_in,
   output logic [OW-1:0]    word
);
   localparam logic [CYC_W-1:0] FIRST = CYC_W'(MSB_CYC);
   localparam logic [CYC_W-1:0] LAST  = CYC_W'(MSB_CYC + DW - 1);

   logic [DW-1:0] sh;
   logic          in_win;

   assign in_win = (cyc >= FIRST) && (cyc <= LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 sh <= '0;
      else if (clr)               sh <= '0;
      else if (sample && in_win)  sh <= {sh[DW-2:0], bit_in};
   end

   generate
      if (OW == DW) begin : g_same
         assign word = sh;
      end else begin : g_ext
         assign word = {{(OW-DW){sh[DW-1]}}, sh};
      end
   endgenerate
endmodule

// File: rtl/dar_ctrl_tx.sv
// Optional control-word shifter; EN=0 ties the line low.
module dar_ctrl_tx #(
   parameter bit EN = 1'b1,
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          load_en,
   input  logic [CW-1:0] word,
   input  logic          shift,
   output logic          sdi
);
   generate
      if (EN) begin : g_tx
         logic [CW-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sr <= '0;
            else if (load)   sr <= load_en ? word : '0;
            else if (shift)  sr <= {sr[CW-2:0], 1'b0};
         end
         assign sdi = sr[CW-1];
      end else begin : g_none
         logic unused_tx;
         assign unused_tx = ^{clk, rst_n, load, load_en, word, shift};
         assign sdi = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader
   import dar_pkg::*;
#(
   parameter int CLK_HALF   = 2,
   parameter int DATA_W     = 12,
   parameter int OUT_W      = 16,
   parameter int SHORT_LEN  = 31,
   parameter int EXTRA_LEN  = 14,
   parameter int A_MSB_EDGE = 19,
   parameter int B_MSB_EDGE = 33,
   parameter int QUIET_W    = 8,
   parameter bit CTRL_EN    = 1'b1,
   parameter int CTRL_W     = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               dual_mode,
   input  logic               line_is_b,
   input  logic [QUIET_W-1:0] quiet_cycles,
   input  logic               ctrl_wr,
   input  logic [CTRL_W-1:0]  ctrl_word,
   input  logic               adc_sdo,
   output logic               sclk,
   output logic               cs_n,
   output logic               adc_sdi,
   output logic               busy,
   output logic               res_valid,
   output logic               res_pair,
   output logic               res_tag,
   output logic [OUT_W-1:0]   res_a,
   output logic [OUT_W-1:0]   res_b
);
   localparam int LONG_LEN = SHORT_LEN + EXTRA_LEN;
   localparam int CYC_W    = $clog2(LONG_LEN + 1);
   localparam int HALF_W   = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
   localparam int TW       = (QUIET_W > HALF_W) ? QUIET_W : HALF_W;

   generate
      if (CLK_HALF < 1) begin : g_bad_half
         $error("CLK_HALF must be at least 1");
      end
      if (DATA_W < 2 || OUT_W < DATA_W) begin : g_bad_width
         $error("need 2 <= DATA_W <= OUT_W");
      end
      if (A_MSB_EDGE < 1 || A_MSB_EDGE + DATA_W - 1 > SHORT_LEN) begin : g_bad_a
         $error("first word window must fit in the short frame");
      end
      if (B_MSB_EDGE <= SHORT_LEN || B_MSB_EDGE + DATA_W - 1 > LONG_LEN) begin : g_bad_b
         $error("second word window must fit in the extension");
      end
      if (CTRL_EN && (CTRL_W < 2 || CTRL_W > SHORT_LEN)) begin : g_bad_ctrl
         $error("CTRL_W must be 2..SHORT_LEN");
      end
   endgenerate

   dar_state_e          state;
   logic                phase;
   logic [CYC_W-1:0]    cyc;
   logic [CYC_W-1:0]    last_cyc;
   logic                dual_q, lineb_q;
   logic                t_done, t_clr;
   logic [TW-1:0]       t_limit;
   logic                launch, sample;
   logic [OUT_W-1:0]    w_first, w_second;
   logic                cs_n_r, sclk_r, valid_r, pair_r, tag_r;
   logic [OUT_W-1:0]    a_r, b_r;

   assign launch   = (state == S_IDLE) && start;
   assign sample   = (state == S_RUN) && !phase && t_done;
   assign t_clr    = (state == S_IDLE);
   assign t_limit  = (state == S_QUIET) ? TW'(quiet_cycles) : TW'(CLK_HALF - 1);
   assign last_cyc = dual_q ? CYC_W'(LONG_LEN) : CYC_W'(SHORT_LEN);

   dar_timer #(.W(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(t_clr), .limit(t_limit), .done(t_done)
   );

   dar_capture #(.DW(DATA_W), .OW(OUT_W), .MSB_CYC(A_MSB_EDGE), .CYC_W(CYC_W)) u_cap_first (
      .clk(clk), .rst_n(rst_n), .clr(launch), .sample(sample), .cyc(cyc),
      .bit_in(adc_sdo), .word(w_first)
   );

   dar_capture #(.DW(DATA_W), .OW(OUT_W), .MSB_CYC(B_MSB_EDGE), .CYC_W(CYC_W)) u_cap_second (
      .clk(clk), .rst_n(rst_n), .clr(launch), .sample(sample), .cyc(cyc),
      .bit_in(adc_sdo), .word(w_second)
   );

   dar_ctrl_tx #(.EN(CTRL_EN), .CW(CTRL_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .load(launch), .load_en(ctrl_wr), .word(ctrl_word),
      .shift(sample), .sdi(adc_sdi)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         phase   <= 1'b0;
         cyc     <= '0;
         dual_q  <= 1'b0;
         lineb_q <= 1'b0;
         cs_n_r  <= 1'b1;
         sclk_r  <= 1'b1;
         valid_r <= 1'b0;
         pair_r  <= 1'b0;
         tag_r   <= 1'b0;
         a_r     <= '0;
         b_r     <= '0;
      end else begin
         valid_r <= 1'b0;
         case (state)
            S_IDLE: if (start) begin
               state   <= S_SETUP;
               cs_n_r  <= 1'b0;
               dual_q  <= dual_mode;
               lineb_q <= line_is_b;
            end
            S_SETUP: if (t_done) begin
               state  <= S_RUN;
               phase  <= 1'b0;
               cyc    <= CYC_W'(1);
               sclk_r <= 1'b0;
            end
            S_RUN: if (t_done) begin
               if (!phase) begin
                  phase  <= 1'b1;
                  sclk_r <= 1'b1;
               end else if (cyc == last_cyc) begin
                  state <= S_HOLD;
               end else begin
                  cyc    <= cyc + 1'b1;
                  phase  <= 1'b0;
                  sclk_r <= 1'b0;
               end
            end
            S_HOLD: if (t_done) begin
               state   <= S_QUIET;
               cs_n_r  <= 1'b1;
               valid_r <= 1'b1;
               pair_r  <= dual_q;
               if (dual_q) begin
                  tag_r <= 1'b0;
                  a_r   <= lineb_q ? w_second : w_first;
                  b_r   <= lineb_q ? w_first  : w_second;
               end else begin
                  tag_r <= lineb_q;
                  a_r   <= lineb_q ? '0 : w_first;
                  b_r   <= lineb_q ? w_first : '0;
               end
            end
            S_QUIET: if (t_done) state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign sclk      = sclk_r;
   assign cs_n      = cs_n_r;
   assign busy      = (state != S_IDLE);
   assign res_valid = valid_r;
   assign res_pair  = pair_r;
   assign res_tag   = tag_r;
   assign res_a     = a_r;
   assign res_b     = b_r;
endmodule

// File: rtl/dar_checker.sv
module dar_checker #(
   parameter int SHORT_LEN = 31,
   parameter int LONG_LEN  = 45
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic dual_mode,
   input logic busy,
   input logic cs_n,
   input logic sclk,
   input logic adc_sdi,
   input logic res_valid
);
   logic       sclk_d;
   logic       mode_q;
   logic [7:0] falls;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b1;
         mode_q <= 1'b0;
         falls  <= '0;
      end else begin
         sclk_d <= sclk;
         if (start && !busy) mode_q <= dual_mode;
         if (cs_n)                      falls <= '0;
         else if (sclk_d && !sclk)      falls <= falls + 1'b1;
      end
   end

   a_r5_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk);

   a_r5_cs_after_high: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> $past(sclk));

   a_r2_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);

   a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   a_r11_valid_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> res_valid);

   a_r4_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (falls == (mode_q ? 8'(LONG_LEN) : 8'(SHORT_LEN))));

   a_r13_sdi_stable_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !sclk) |-> $stable(adc_sdi));
endmodule

bind dual_adc_reader dar_checker #(
   .SHORT_LEN(SHORT_LEN),
   .LONG_LEN(SHORT_LEN + EXTRA_LEN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .dual_mode(dual_mode), .busy(busy),
   .cs_n(cs_n), .sclk(sclk), .adc_sdi(adc_sdi), .res_valid(res_valid)
);

// File: tb/sim_dual_adc_reader.sv
module sim_dual_adc_reader;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 12;

   typedef struct {
      logic [15:0] a;
      logic [15:0] b;
      logic        pair;
      logic        tag;
      int          edges;
      logic [CW-1:0] rx;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, dual_mode = 1'b0, line_is_b = 1'b0, ctrl_wr = 1'b0;
   logic [7:0] quiet_cycles = 8'd0;
   logic [CW-1:0] ctrl_word = '0;
   logic adc_sdo = 1'b1;
   logic sclk, cs_n, adc_sdi, busy, res_valid, res_pair, res_tag;
   logic [15:0] res_a, res_b;

   int checks = 0, errors = 0, valids = 0;
   exp_t exp_q[$];

   logic [11:0] dev_a = '0, dev_b = '0;
   logic        dev_lineb = 1'b0;
   int          dev_k = 0;
   logic [CW-1:0] dev_rx = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_adc_reader u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .dual_mode(dual_mode), .line_is_b(line_is_b),
      .quiet_cycles(quiet_cycles), .ctrl_wr(ctrl_wr), .ctrl_word(ctrl_word),
      .adc_sdo(adc_sdo), .sclk(sclk), .cs_n(cs_n), .adc_sdi(adc_sdi), .busy(busy),
      .res_valid(res_valid), .res_pair(res_pair), .res_tag(res_tag),
      .res_a(res_a), .res_b(res_b)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] sx(input logic [11:0] v);
      return {{4{v[11]}}, v};
   endfunction

   // device model: garbage outside result windows, bits change on falling sclk
   always @(negedge cs_n) begin
      dev_k  = 0;
      dev_rx = '0;
      adc_sdo = 1'b1;
   end
   always @(negedge sclk) begin
      if (!cs_n) begin
         logic [11:0] w1, w2;
         w1 = dev_lineb ? dev_b : dev_a;
         w2 = dev_lineb ? dev_a : dev_b;
         dev_k = dev_k + 1;
         if (dev_k <= CW) dev_rx = {dev_rx[CW-2:0], adc_sdi};
         if (dev_k >= 19 && dev_k <= 30)      adc_sdo = w1[30-dev_k];
         else if (dev_k >= 33 && dev_k <= 44) adc_sdo = w2[44-dev_k];
         else                                 adc_sdo = dev_k[0];
      end
   end

   // monitor: scoreboard pop, pulse width, quiet gap
   logic prev_valid = 1'b0, prev_cs = 1'b1;
   int   hi_cnt = 0, frames = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (res_valid) begin
            valids++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3 unexpected result", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(res_a == e.a, "R6/R8/R9/R10 res_a", res_a, e.a);
               chk(res_b == e.b, "R7/R8/R9/R10 res_b", res_b, e.b);
               chk(res_pair == e.pair, "R9/R10 res_pair", res_pair, e.pair);
               chk(res_tag == e.tag, "R10 res_tag", res_tag, e.tag);
               chk(dev_k == e.edges, "R4 edge count", dev_k, e.edges);
               chk(dev_rx == e.rx, "R13 control word", dev_rx, e.rx);
               chk(cs_n == 1'b1, "R11 valid with cs_n high", cs_n, 1);
            end
         end
         if (prev_valid && res_valid) chk(1'b0, "R11 pulse width", 2, 1);
         if (!cs_n && prev_cs && frames > 0)
            chk(hi_cnt >= int'(quiet_cycles) + 1, "R12 quiet gap", hi_cnt, int'(quiet_cycles) + 1);
         if (!cs_n && prev_cs) frames++;
         if (cs_n && !sclk) chk(1'b0, "R5 sclk low while idle", 0, 1);
         hi_cnt = cs_n ? hi_cnt + 1 : 0;
         prev_valid = res_valid;
         prev_cs = cs_n;
      end
   end

   task automatic push(input logic [11:0] a, input logic [11:0] b, input logic dual,
                       input logic lb, input logic wr, input logic [CW-1:0] cw);
      exp_t e;
      if (dual) begin
         e.a = sx(a); e.b = sx(b); e.pair = 1'b1; e.tag = 1'b0; e.edges = 45;
      end else begin
         e.a = lb ? 16'h0 : sx(a); e.b = lb ? sx(b) : 16'h0;
         e.pair = 1'b0; e.tag = lb; e.edges = 31;
      end
      e.rx = wr ? cw : '0;
      exp_q.push_back(e);
   endtask

   task automatic run_frame(input logic [11:0] a, input logic [11:0] b, input logic dual,
                            input logic lb, input logic wr, input logic [CW-1:0] cw);
      @(negedge clk);
      dev_a = a; dev_b = b; dev_lineb = lb;
      dual_mode = dual; line_is_b = lb; ctrl_wr = wr; ctrl_word = cw;
      push(a, b, dual, lb, wr, cw);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(cs_n == 1'b0, "R2 cs_n low after start", cs_n, 0);
      chk(busy == 1'b1, "R2 busy after start", busy, 1);
      while (busy) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
      chk(sclk == 1'b1, "R1 sclk in reset", sclk, 1);
      chk(busy == 1'b0, "R1 busy in reset", busy, 0);
      chk(res_valid == 1'b0, "R1 valid in reset", res_valid, 0);
      chk(adc_sdi == 1'b0, "R1 sdi in reset", adc_sdi, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(cs_n == 1'b1 && busy == 1'b0, "R1 idle after reset", {cs_n, busy}, 2'b10);

      run_frame(12'h123, 12'h000, 1'b0, 1'b0, 1'b0, '0);          // R10 short, line A
      run_frame(12'h000, 12'h800, 1'b0, 1'b1, 1'b0, '0);          // R8 R10 negative on B
      run_frame(12'hFFF, 12'h7FF, 1'b1, 1'b0, 1'b0, '0);          // R9 long, line A
      run_frame(12'h5A5, 12'hA5A, 1'b1, 1'b1, 1'b0, '0);          // R9 long, line B
      run_frame(12'hC3A, 12'h000, 1'b0, 1'b0, 1'b1, 12'hC3A);     // R13 control word
      run_frame(12'h001, 12'h9AB, 1'b1, 1'b0, 1'b1, 12'h5F1);     // R6 R7 R13 long

      // R3: start pulse inside a busy frame is dropped
      begin
         int v0;
         v0 = valids;
         @(negedge clk);
         dev_a = 12'h456; dev_b = 12'h000; dev_lineb = 1'b0;
         dual_mode = 1'b0; line_is_b = 1'b0; ctrl_wr = 1'b0;
         push(12'h456, 12'h000, 1'b0, 1'b0, 1'b0, '0);
         start = 1'b1; @(negedge clk); start = 1'b0;
         repeat (40) @(negedge clk);
         chk(busy == 1'b1, "R3 still busy mid-frame", busy, 1);
         start = 1'b1; @(negedge clk); start = 1'b0;
         while (busy) @(negedge clk);
         repeat (200) @(negedge clk);
         chk(valids == v0 + 1, "R3 one result only", valids - v0, 1);
         chk(busy == 1'b0 && cs_n == 1'b1, "R3 no extra frame", {busy, cs_n}, 2'b01);
      end

      // R12: start held through two long frames with a quiet time
      begin
         int v0;
         v0 = valids;
         @(negedge clk);
         quiet_cycles = 8'd5;
         dev_a = 12'h321; dev_b = 12'hCDE; dev_lineb = 1'b0;
         dual_mode = 1'b1; line_is_b = 1'b0; ctrl_wr = 1'b0;
         push(12'h321, 12'hCDE, 1'b1, 1'b0, 1'b0, '0);
         push(12'h321, 12'hCDE, 1'b1, 1'b0, 1'b0, '0);
         start = 1'b1;
         while (valids < v0 + 2) @(negedge clk);
         start = 1'b0;
         while (busy) @(negedge clk);
         chk(valids == v0 + 2, "R12 two back-to-back frames", valids - v0, 2);
      end

      repeat (10) @(negedge clk);
      chk(exp_q.size() == 0, "R11 all results seen", exp_q.size(), 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule